// File: doc/BRIEF.md
# Power-Gated Periodic ADC Sampler

This controller drives an external 8-bit parallel analog-to-digital converter and keeps it unpowered except while a sample is being taken. A sample request comes from a one-cycle command pulse or from an internal interval timer. Each accepted request runs the same sequence. The converter supply is enabled and a programmable settle time passes. A start strobe is issued, and the controller waits a fixed conversion time derived from the clock rate. A read strobe then latches the data bus. An interrupt is raised, and the supply is switched off again.

Software sees a small register-style write port. Through it software sets the sampling interval, the settle delay and a master enable. Software also has an interrupt-acknowledge input. A result that completes while the previous interrupt is still pending is flagged as an overrun. While a sample is running, at most one further request is remembered.

Top module: `adc_smp_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to its idle state. `adc_pwr_en`, `adc_start`, `adc_rd`, `irq` and `overrun` are 0 and `smp_result` is 0. After reset the interval is 0, the settle delay is 8 and the master enable is 0.
- R2: When the master enable is 1, a `smp_cmd` pulse seen in an idle cycle starts a sample, and `adc_pwr_en` rises in the next cycle.
- R3: `adc_pwr_en` is high for settle+1 cycles before the conversion phase. `adc_start` is high for exactly one cycle, which is the last of those cycles.
- R4: The conversion phase lasts ceil(CLK_MHZ*CONV_NS/1000) cycles, which is 225 at the defaults. `adc_rd` is then high for one cycle, and `smp_result` takes the value on `adc_data` at the end of that cycle.
- R5: `irq` is high from the cycle after the read strobe. `adc_pwr_en` stays high for one more cycle and then falls.
- R6: With the master enable set and an interval N other than 0, a periodic request fires N cycles after the interval register is written and every N cycles after that.
- R7: An interval of 0 stops periodic requests. Command pulses still start samples.
- R8: With the master enable at 0, commands and the timer start nothing and any held request is dropped. A sample already running still completes.
- R9: Requests that arrive while a sample is running, including several commands, leave exactly one held request. That request starts one further sample once the block is idle.
- R10: `irq` stays high until an `irq_ack` pulse. `irq_ack` clears both `irq` and `overrun`.
- R11: A result that completes while `irq` is high and `irq_ack` is low sets `overrun`. If `irq_ack` is high in the read-strobe cycle, `irq` stays high for the new result and `overrun` ends at 0.
- R12: A reset in the middle of a sample switches the converter power off at the next edge.
- R13: Configuration writes use `cfg_sel`. Code 0 writes the interval from `cfg_wdata`. Code 1 writes the settle delay from `cfg_wdata[7:0]`. Code 2 writes the master enable from `cfg_wdata[0]`. Code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 16 | Configuration write data |
| smp_cmd | input | 1 | One-cycle sample command |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| adc_data | input | 8 | Converter data bus |
| adc_pwr_en | output | 1 | Converter supply enable |
| adc_start | output | 1 | Conversion start strobe |
| adc_rd | output | 1 | Result read strobe |
| smp_result | output | 8 | Latest latched result |
| irq | output | 1 | Sample-complete interrupt |
| overrun | output | 1 | Result completed before acknowledge |

## Verification
Two events can land on the same clock edge: completion of a new result and the acknowledge of the previous one. The bench leaves one interrupt unacknowledged, starts another sample, and asserts `irq_ack` exactly in the cycle it expects the read strobe. It then checks that `irq` stays set and `overrun` stays clear. A second overlap is also exercised: requests arriving while a sample is in flight, set against the single held request. A behavioural model counts cycles since each accepted request and is compared with every output on every clock.

// File: rtl/adc_smp_pkg.sv
// Shared types and helpers for the power-gated ADC sampler.
// Assumes conversion time and clock rate are given as whole numbers.
package adc_smp_pkg;

    // Sequencer phases of one sample
    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_PWRUP = 3'd1,
        ST_CONV  = 3'd2,
        ST_READ  = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_t;

    // Configuration register select codes
    localparam logic [1:0] SEL_IVL    = 2'd0;
    localparam logic [1:0] SEL_SETTLE = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;

    // Conversion wait in clock cycles, rounded up
    function automatic int conv_cycles(input int clk_mhz, input int conv_ns);
        return (clk_mhz * conv_ns + 999) / 1000;
    endfunction

endpackage

// File: rtl/adc_smp_cfg.sv
// Configuration registers: interval, settle delay and master enable.
// Assumes one write per cycle; the unused select code is ignored.
module adc_smp_cfg #(
    parameter int CFG_W      = 16,
    parameter int SETL_W     = 8,
    parameter int SETTLE_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  ivl,
    output logic [SETL_W-1:0] settle,
    output logic              en,
    output logic              ivl_wr
);
    import adc_smp_pkg::*;

    // Strobe telling the timer to restart its phase
    assign ivl_wr = we && (sel == SEL_IVL);

    // Register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivl    <= '0;
            settle <= SETL_W'(SETTLE_RST);
            en     <= 1'b0;
        end else if (we) begin
            case (sel)
                SEL_IVL:    ivl    <= wdata;
                SEL_SETTLE: settle <= wdata[SETL_W-1:0];
                SEL_CTRL:   en     <= wdata[0];
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/adc_smp_timer.sv
// Interval timer: one-cycle tick every ivl cycles while enabled.
// Assumes ivl == 0 means periodic sampling is off.
module adc_smp_timer #(
    parameter int CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CFG_W-1:0] ivl,
    input  logic             ivl_wr,
    output logic             tick
);
    logic [CFG_W-1:0] cnt;
    logic             run;

    assign run  = en && (ivl != '0);
    assign tick = run && (cnt == ivl - CFG_W'(1));

    // Phase counter, restarted by interval writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ivl_wr || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + CFG_W'(1);
    end
endmodule

// File: rtl/adc_smp_seq.sv
// Sample sequencer: holds one request, powers the converter, waits
// settle and conversion time, strobes the read and latches the result.
// Assumes CONV_CYC >= 1 and the counter is wide enough for both waits.
module adc_smp_seq #(
    parameter int DATA_W   = 8,
    parameter int SETL_W   = 8,
    parameter int CONV_CYC = 225
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cmd,
    input  logic              tick,
    input  logic [SETL_W-1:0] settle,
    input  logic [DATA_W-1:0] adc_data,
    output logic              pwr_en,
    output logic              start,
    output logic              rd,
    output logic              done,
    output logic [DATA_W-1:0] result
);
    import adc_smp_pkg::*;

    localparam int CONV_W = $clog2(CONV_CYC + 1);
    localparam int SEQ_W  = (CONV_W > SETL_W) ? CONV_W : SETL_W;

    seq_state_t       state;
    logic [SEQ_W-1:0] cnt;
    logic             pend;
    logic             req;
    logic             accept;
    logic             cnt_zero;

    assign req      = en && (cmd || tick);
    assign accept   = (state == ST_OFF) && en && (pend || req);
    assign cnt_zero = (cnt == '0);

    assign pwr_en = (state != ST_OFF);
    assign start  = (state == ST_PWRUP) && cnt_zero;
    assign rd     = (state == ST_READ);
    assign done   = (state == ST_READ);

    // Single held request; merges repeats, dropped when disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !en || accept)
            pend <= 1'b0;
        else
            pend <= pend || req;
    end

    // Phase sequencer with shared down-counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
            cnt   <= '0;
        end else begin
            case (state)
                ST_OFF: begin
                    if (accept) begin
                        state <= ST_PWRUP;
                        cnt   <= SEQ_W'(settle);
                    end
                end
                ST_PWRUP: begin
                    if (cnt_zero) begin
                        state <= ST_CONV;
                        cnt   <= SEQ_W'(CONV_CYC - 1);
                    end else begin
                        cnt <= cnt - SEQ_W'(1);
                    end
                end
                ST_CONV: begin
                    if (cnt_zero)
                        state <= ST_READ;
                    else
                        cnt <= cnt - SEQ_W'(1);
                end
                ST_READ: state <= ST_DONE;
                ST_DONE: state <= ST_OFF;
                default: state <= ST_OFF;
            endcase
        end
    end

    // Result latch at the end of the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else if (state == ST_READ)
            result <= adc_data;
    end
endmodule

// File: rtl/adc_smp_irq.sv
// Completion interrupt with overrun flag.
// Assumes done is a one-cycle pulse; acknowledge of the old result
// in the same cycle as a new completion is not an overrun.
module adc_smp_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic ack,
    output logic irq,
    output logic overrun
);
    // Interrupt and overrun update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (done)
                irq <= 1'b1;
            else if (ack)
                irq <= 1'b0;

            if (ack)
                overrun <= 1'b0;
            else if (done && irq)
                overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_smp_top.sv
// Power-gated periodic ADC sampler top level.
// Assumes an external converter with power enable, start and read
// strobes and a parallel data bus valid during the read strobe.
module adc_smp_top #(
    parameter int DATA_W     = 8,
    parameter int CFG_W      = 16,
    parameter int SETL_W     = 8,
    parameter int SETTLE_RST = 8,
    parameter int CLK_MHZ    = 125,
    parameter int CONV_NS    = 1800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              smp_cmd,
    input  logic              irq_ack,
    input  logic [DATA_W-1:0] adc_data,
    output logic              adc_pwr_en,
    output logic              adc_start,
    output logic              adc_rd,
    output logic [DATA_W-1:0] smp_result,
    output logic              irq,
    output logic              overrun
);
    localparam int CONV_CYC = adc_smp_pkg::conv_cycles(CLK_MHZ, CONV_NS);

    logic [CFG_W-1:0]  ivl;
    logic [SETL_W-1:0] settle;
    logic              en;
    logic              ivl_wr;
    logic              tick;
    logic              done;

    adc_smp_cfg #(.CFG_W(CFG_W), .SETL_W(SETL_W), .SETTLE_RST(SETTLE_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .ivl(ivl), .settle(settle), .en(en), .ivl_wr(ivl_wr)
    );

    adc_smp_timer #(.CFG_W(CFG_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .ivl(ivl), .ivl_wr(ivl_wr), .tick(tick)
    );

    adc_smp_seq #(.DATA_W(DATA_W), .SETL_W(SETL_W), .CONV_CYC(CONV_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .cmd(smp_cmd), .tick(tick),
        .settle(settle), .adc_data(adc_data), .pwr_en(adc_pwr_en),
        .start(adc_start), .rd(adc_rd), .done(done), .result(smp_result)
    );

    adc_smp_irq u_irq (
        .clk(clk), .rst_n(rst_n), .done(done), .ack(irq_ack),
        .irq(irq), .overrun(overrun)
    );
endmodule

// File: rtl/adc_smp_chk.sv
// Protocol checks on the sampler's ports, bound to the top level.
module adc_smp_chk (
    input logic clk,
    input logic rst_n,
    input logic irq_ack,
    input logic adc_pwr_en,
    input logic adc_start,
    input logic adc_rd,
    input logic irq,
    input logic overrun
);
    // R3
    start_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> adc_pwr_en);

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R4
    read_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rd |-> (adc_pwr_en && !adc_start));

    // R5
    irq_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_rd |=> irq);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R11
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(irq) && $past(adc_rd) && !$past(irq_ack)));
endmodule

bind adc_smp_top adc_smp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .adc_pwr_en(adc_pwr_en),
    .adc_start(adc_start), .adc_rd(adc_rd), .irq(irq), .overrun(overrun)
);

// File: tb/tb_adc_smp_top.sv
module tb_adc_smp_top;
    localparam int CONV = (125 * 1800 + 999) / 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        smp_cmd = 1'b0;
    logic        irq_ack = 1'b0;
    logic [7:0]  adc_data = 8'h11;
    logic        adc_pwr_en, adc_start, adc_rd, irq, overrun;
    logic [7:0]  smp_result;

    always #4 clk = ~clk;

    adc_smp_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .smp_cmd(smp_cmd), .irq_ack(irq_ack),
        .adc_data(adc_data), .adc_pwr_en(adc_pwr_en), .adc_start(adc_start),
        .adc_rd(adc_rd), .smp_result(smp_result), .irq(irq), .overrun(overrun)
    );

    int    n_chk = 0, n_bad = 0;
    bit    cmp_on = 0;
    string phase = "R1";
    int    rises = 0;
    bit    prev_pwr = 0;

    // Behavioural model state
    int m_en, m_ivl, m_settle, m_tcnt, m_pend, m_active, m_age, m_sl, m_irq, m_ovr, m_res;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d at %0t", tag, phase, what, act, exp, $time);
        end
    endtask

    // Model: cycles since acceptance drive all expected strobes
    always @(posedge clk) begin : model
        int tick, req, acc, done;
        if (!rst_n) begin
            m_en = 0; m_ivl = 0; m_settle = 8; m_tcnt = 0; m_pend = 0;
            m_active = 0; m_age = 0; m_sl = 0; m_irq = 0; m_ovr = 0; m_res = 0;
            cmp_on = 1;
        end else begin
            tick = (m_en != 0 && m_ivl != 0 && m_tcnt == m_ivl - 1) ? 1 : 0;
            req  = (m_en != 0 && (smp_cmd || tick != 0)) ? 1 : 0;
            acc  = (m_active == 0 && m_en != 0 && (m_pend != 0 || req != 0)) ? 1 : 0;
            done = (m_active != 0 && m_age == m_sl + CONV + 2) ? 1 : 0;
            if (done != 0) begin
                m_ovr = irq_ack ? 0 : ((m_ovr != 0 || m_irq != 0) ? 1 : 0);
                m_irq = 1;
                m_res = adc_data;
            end else if (irq_ack) begin
                m_irq = 0; m_ovr = 0;
            end
            if (m_active != 0) begin
                if (m_age == m_sl + CONV + 3) m_active = 0;
                else m_age++;
            end else if (acc != 0) begin
                m_active = 1; m_age = 1; m_sl = m_settle;
            end
            if (m_en == 0 || acc != 0) m_pend = 0;
            else m_pend = (m_pend != 0 || req != 0) ? 1 : 0;
            if ((cfg_we && cfg_sel == 2'd0) || m_en == 0 || m_ivl == 0 || tick != 0) m_tcnt = 0;
            else m_tcnt++;
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: m_ivl = cfg_wdata;
                    2'd1: m_settle = cfg_wdata[7:0];
                    2'd2: m_en = cfg_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    // Compare every output each cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R2", "adc_pwr_en", adc_pwr_en, m_active);
            chk("R3", "adc_start", adc_start, (m_active != 0 && m_age == m_sl + 1) ? 1 : 0);
            chk("R4", "adc_rd", adc_rd, (m_active != 0 && m_age == m_sl + CONV + 2) ? 1 : 0);
            chk("R4", "smp_result", smp_result, m_res);
            chk("R10", "irq", irq, m_irq);
            chk("R11", "overrun", overrun, m_ovr);
            if (adc_pwr_en && !prev_pwr) rises++;
        end
        prev_pwr = adc_pwr_en;
        adc_data <= adc_data + 8'd37;
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input int data);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic cmd();
        @(negedge clk); smp_cmd = 1;
        @(negedge clk); smp_cmd = 0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1;
        @(negedge clk); irq_ack = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
    end

    initial begin : stim
        int base;
        cycles(3);
        // R1: reset state
        chk("R1", "pwr in reset", adc_pwr_en, 0);
        chk("R1", "irq in reset", irq, 0);
        chk("R1", "result in reset", smp_result, 0);
        rst_n = 1;

        // R8: enable is 0 after reset, command ignored
        phase = "R8 disabled";
        base = rises;
        cmd(); cycles(20);
        chk("R8", "no sample while disabled", rises - base, 0);

        // R13: select code 3 ignored, then real settings
        phase = "R13";
        wr(2'd3, 16'hFFFF);
        wr(2'd1, 3); wr(2'd2, 1);

        // R2 R3 R4 R5: single commanded sample
        phase = "R2 R3 R4 R5";
        cmd(); cycles(260);
        chk("R5", "irq after sample", irq, 1);
        chk("R5", "power off after sample", adc_pwr_en, 0);
        ack(); cycles(2);
        chk("R10", "irq cleared by ack", irq, 0);

        // R11: overrun when second result lands unacknowledged
        phase = "R11 overrun";
        cmd(); cycles(260);
        cmd(); cycles(260);
        chk("R11", "overrun set", overrun, 1);
        ack(); cycles(2);
        chk("R10", "ack clears overrun", overrun, 0);

        // R11: acknowledge in the same cycle as completion
        phase = "R11 ack with done";
        cmd(); cycles(260);
        cmd();
        while (!(m_active != 0 && m_age == m_sl + CONV + 2)) @(negedge clk);
        irq_ack = 1;
        @(negedge clk); irq_ack = 0;
        chk("R11", "irq kept for new result", irq, 1);
        chk("R11", "no overrun on coincident ack", overrun, 0);
        ack(); cycles(10);

        // R9: repeated requests during a sample hold one request
        phase = "R9";
        base = rises;
        cmd(); cycles(5); cmd(); cycles(40); cmd(); cmd(); cycles(100); cmd();
        cycles(700);
        chk("R9", "one follow-on sample", rises - base, 2);
        ack();

        // R6: periodic sampling
        phase = "R6";
        wr(2'd0, 300);
        base = rises;
        cycles(1350);
        chk("R6", "periodic samples", rises - base, 4);

        // R7: interval zero stops timer, commands still work
        phase = "R7";
        wr(2'd0, 0);
        cycles(400);
        base = rises;
        cycles(900);
        chk("R7", "no periodic sample", rises - base, 0);
        cmd(); cycles(260);
        chk("R7", "command still works", rises - base, 1);
        ack();

        // R8: disable mid-sample drops held requests
        phase = "R8";
        wr(2'd0, 50);
        cmd(); cycles(20);
        wr(2'd2, 0);
        cycles(400);
        base = rises;
        cmd(); cycles(500);
        chk("R8", "nothing after disable", rises - base, 0);
        chk("R8", "power off", adc_pwr_en, 0);
        wr(2'd0, 0); wr(2'd2, 1);

        // R12: reset during a sample
        phase = "R12";
        cmd(); cycles(30);
        rst_n = 0;
        @(negedge clk);
        chk("R12", "power off after mid-sample reset", adc_pwr_en, 0);
        rst_n = 1;
        cycles(5);
        summary();
    end
endmodule